// File: doc/BRIEF.md
# Shared-Memory Doorbell Register Bank

This block is the control register bank of a device that lets several peers share a memory region and interrupt one another. It decodes a 256-byte window on a simple synchronous register bus. The bus has an address, a write strobe, write data, a read strobe and registered read data. Four word registers sit at the bottom of the window; the rest of the window reads as zero and ignores writes.

The bank holds an interrupt mask word and an interrupt status word. Both are fully writable and read back exactly what was written. It also has a read-only position word that shows the local device ID when interrupts are enabled, and a write-only doorbell word. A doorbell write splits the written word into a target peer ID and a vector number. It then emits a single-cycle ring request to the inter-peer transport, but only when interrupts are enabled.

Three configuration inputs set the behaviour: the device revision, whether interrupts are enabled, and the local ID. In revision 0, bit 0 of mask and status is the live peer-interrupt bit. An incoming peer event sets status bit 0, and the interrupt output follows mask bit 0 AND status bit 0. In revision 1 that bit is an inert storage bit.

Top module: `shm_bell_bank`

## Requirements
- R1: After reset the mask and status words read 0, and irq_out, ring_req and bus_rdata are 0.
- R2: The mask word (byte offset 0x00) and the status word (offset 0x04) store all 32 written bits and read back unchanged.
- R3: Read data appears on bus_rdata in the cycle after the cycle in which bus_rd is high, and is 0 in any cycle that does not follow a read. Address bits 1:0 are ignored, so only word-aligned accesses are meaningful.
- R4: The position word (offset 0x08) reads {16'h0, cfg_local_id} when cfg_irq_en is 1 and reads 0 when cfg_irq_en is 0. Writes to it change nothing.
- R5: A write to the doorbell word (offset 0x0C) while cfg_irq_en is 1 drives ring_req high for exactly the next cycle. In that cycle ring_peer equals the written bits 31:16 and ring_vector equals bits 15:0. Writes on consecutive cycles give one pulse per write, each carrying its own data.
- R6: A doorbell write while cfg_irq_en is 0 is discarded, and ring_req stays 0.
- R7: The doorbell word and every reserved offset 0x10 to 0xFC read 0. Writes to reserved offsets leave the mask and status words unchanged.
- R8: With cfg_rev = 0 and cfg_irq_en = 1, a cycle with peer_irq_in high sets status bit 0 from the next cycle on. This holds even when a bus write to status in the same cycle clears it. With cfg_rev = 1, or with cfg_irq_en = 0, peer_irq_in has no effect.
- R9: irq_out is 1 exactly when cfg_rev = 0 and the stored mask bit 0 and status bit 0 are both 1. It is 0 whenever cfg_rev = 1.
- R10: In revision 0, writing status bit 0 back to 0 drops irq_out in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_rev | input | 1 | Device revision: 0 = live peer-interrupt bit, 1 = bit reserved |
| cfg_irq_en | input | 1 | Interrupts configured |
| cfg_local_id | input | 16 | Local device ID |
| bus_addr | input | 8 | Byte address within the window |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| peer_irq_in | input | 1 | Incoming peer interrupt event |
| ring_req | output | 1 | One-cycle request to interrupt a peer |
| ring_peer | output | 16 | Target peer ID of the request |
| ring_vector | output | 16 | Vector number of the request |
| irq_out | output | 1 | Local interrupt output |

## Verification
The bench writes patterns with reserved high bits set into mask and status and checks that they come back whole; a bank that masked reserved bits would return truncated words. It rings the doorbell with interrupts on and off, and also on two consecutive cycles. A gate that ignored the enable would leak requests, and a stretched or merged strobe would show the wrong width or stale peer and vector. A peer event is raised in the same cycle as a software clear of status, to catch a bank in which the bus write wins. Revision 1 is used with mask and status bit 0 set, so an interrupt that ignores the revision would show on irq_out. Reserved and doorbell reads, position reads under both enable settings, and the idle cycle after each read expose decode holes and read data that lingers.

// File: rtl/shm_bell_pkg.sv
package shm_bell_pkg;

    localparam int WIN_ADDR_W = 8;
    localparam int REG_W      = 32;
    localparam int ID_W       = 16;
    localparam int WORD_IDX_W = WIN_ADDR_W - 2;

    localparam logic [WORD_IDX_W-1:0] IDX_MASK   = WORD_IDX_W'(0);
    localparam logic [WORD_IDX_W-1:0] IDX_STATUS = WORD_IDX_W'(1);
    localparam logic [WORD_IDX_W-1:0] IDX_POS    = WORD_IDX_W'(2);
    localparam logic [WORD_IDX_W-1:0] IDX_BELL   = WORD_IDX_W'(3);

    typedef enum logic [2:0] {
        SEL_MASK,
        SEL_STATUS,
        SEL_POS,
        SEL_BELL,
        SEL_RSVD
    } reg_sel_e;

    typedef struct packed {
        logic [ID_W-1:0] peer;
        logic [ID_W-1:0] vector;
    } ring_msg_t;

    typedef struct packed {
        logic mask;
        logic status;
        logic bell;
    } wr_strobe_t;

    function automatic reg_sel_e word_to_sel(input logic [WORD_IDX_W-1:0] idx);
        case (idx)
            IDX_MASK:   return SEL_MASK;
            IDX_STATUS: return SEL_STATUS;
            IDX_POS:    return SEL_POS;
            IDX_BELL:   return SEL_BELL;
            default:    return SEL_RSVD;
        endcase
    endfunction

    function automatic ring_msg_t split_bell(input logic [REG_W-1:0] w);
        ring_msg_t m;
        m.peer   = w[REG_W-1 -: ID_W];
        m.vector = w[ID_W-1:0];
        return m;
    endfunction

endpackage

// File: rtl/shm_bell_decode.sv
module shm_bell_decode
    import shm_bell_pkg::*;
(
    input  logic [WIN_ADDR_W-1:0] addr,
    input  logic                  wr,
    output reg_sel_e              sel,
    output wr_strobe_t            wstb
);
    logic unused_lo;
    assign unused_lo = ^addr[1:0];

    always_comb begin
        sel         = word_to_sel(addr[WIN_ADDR_W-1:2]);
        wstb.mask   = wr && (sel == SEL_MASK);
        wstb.status = wr && (sel == SEL_STATUS);
        wstb.bell   = wr && (sel == SEL_BELL);
    end

    always_comb begin
        // R7
        rsvd_no_strobe_chk: assert ((sel != SEL_RSVD) || (wstb == '0));
    end
endmodule

// File: rtl/shm_bell_regs.sv
module shm_bell_regs
    import shm_bell_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_rev,
    input  logic             cfg_irq_en,
    input  wr_strobe_t       wstb,
    input  logic [REG_W-1:0] wdata,
    input  logic             peer_irq_in,
    output logic [REG_W-1:0] mask_q,
    output logic [REG_W-1:0] status_q,
    output logic             irq_out
);
    logic             peer_evt;
    logic [REG_W-1:0] status_d;

    assign peer_evt = peer_irq_in && cfg_irq_en && !cfg_rev;

    always_comb begin
        status_d = wstb.status ? wdata : status_q;
        if (peer_evt) status_d[0] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q   <= '0;
            status_q <= '0;
        end else begin
            if (wstb.mask) mask_q <= wdata;
            status_q <= status_d;
        end
    end

    assign irq_out = !cfg_rev && mask_q[0] && status_q[0];

    // R2
    mask_readback_chk: assert property (@(posedge clk) disable iff (rst)
        wstb.mask |=> (mask_q == $past(wdata)));
    // R8
    peer_set_chk: assert property (@(posedge clk) disable iff (rst)
        (peer_irq_in && cfg_irq_en && !cfg_rev) |=> status_q[0]);
    // R9
    irq_rev_chk: assert property (@(posedge clk) disable iff (rst)
        irq_out |-> !cfg_rev);
endmodule

// File: rtl/shm_bell_ring.sv
module shm_bell_ring
    import shm_bell_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_irq_en,
    input  logic             wr_bell,
    input  logic [REG_W-1:0] wdata,
    output logic             ring_req,
    output ring_msg_t        ring_msg
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ring_req <= 1'b0;
            ring_msg <= '0;
        end else begin
            ring_req <= wr_bell && cfg_irq_en;
            if (wr_bell && cfg_irq_en) ring_msg <= split_bell(wdata);
        end
    end

    // R6
    bell_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_bell && !cfg_irq_en) |=> !ring_req);
    // R5
    bell_cause_chk: assert property (@(posedge clk) disable iff (rst)
        ring_req |-> $past(wr_bell && cfg_irq_en));
    // R5
    bell_data_chk: assert property (@(posedge clk) disable iff (rst)
        ring_req |-> (ring_msg.vector == $past(wdata[ID_W-1:0])));
endmodule

// File: rtl/shm_bell_rdmux.sv
module shm_bell_rdmux
    import shm_bell_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             rd,
    input  reg_sel_e         sel,
    input  logic             cfg_irq_en,
    input  logic [ID_W-1:0]  cfg_local_id,
    input  logic [REG_W-1:0] mask_q,
    input  logic [REG_W-1:0] status_q,
    output logic [REG_W-1:0] rdata
);
    logic [REG_W-1:0] pos_word;
    logic [REG_W-1:0] rd_d;

    assign pos_word = cfg_irq_en ? REG_W'(cfg_local_id) : '0;

    always_comb begin
        case (sel)
            SEL_MASK:   rd_d = mask_q;
            SEL_STATUS: rd_d = status_q;
            SEL_POS:    rd_d = pos_word;
            default:    rd_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) rdata <= '0;
        else     rdata <= rd ? rd_d : '0;
    end

    // R3
    rd_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rd) |-> (rdata == '0));
    // R4
    pos_hidden_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(rd) && ($past(sel) == SEL_POS) && !$past(cfg_irq_en)) |-> (rdata == '0));
    // R7
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(rd) && (($past(sel) == SEL_RSVD) || ($past(sel) == SEL_BELL))) |-> (rdata == '0));
endmodule

// File: rtl/shm_bell_bank.sv
module shm_bell_bank
    import shm_bell_pkg::*;
#(
    parameter int ADDR_W = WIN_ADDR_W,
    parameter int DATA_W = REG_W,
    parameter int PID_W  = ID_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_rev,
    input  logic              cfg_irq_en,
    input  logic [PID_W-1:0]  cfg_local_id,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              peer_irq_in,
    output logic              ring_req,
    output logic [PID_W-1:0]  ring_peer,
    output logic [PID_W-1:0]  ring_vector,
    output logic              irq_out
);
    reg_sel_e         sel;
    wr_strobe_t       wstb;
    logic [REG_W-1:0] mask_q;
    logic [REG_W-1:0] status_q;
    ring_msg_t        ring_msg;

    shm_bell_decode u_decode (
        .addr (bus_addr),
        .wr   (bus_wr),
        .sel  (sel),
        .wstb (wstb)
    );

    shm_bell_regs u_regs (
        .clk         (clk),
        .rst         (rst),
        .cfg_rev     (cfg_rev),
        .cfg_irq_en  (cfg_irq_en),
        .wstb        (wstb),
        .wdata       (bus_wdata),
        .peer_irq_in (peer_irq_in),
        .mask_q      (mask_q),
        .status_q    (status_q),
        .irq_out     (irq_out)
    );

    shm_bell_ring u_ring (
        .clk        (clk),
        .rst        (rst),
        .cfg_irq_en (cfg_irq_en),
        .wr_bell    (wstb.bell),
        .wdata      (bus_wdata),
        .ring_req   (ring_req),
        .ring_msg   (ring_msg)
    );

    shm_bell_rdmux u_rdmux (
        .clk          (clk),
        .rst          (rst),
        .rd           (bus_rd),
        .sel          (sel),
        .cfg_irq_en   (cfg_irq_en),
        .cfg_local_id (cfg_local_id),
        .mask_q       (mask_q),
        .status_q     (status_q),
        .rdata        (bus_rdata)
    );

    assign ring_peer   = ring_msg.peer;
    assign ring_vector = ring_msg.vector;

    // R10
    irq_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (wstb.status && !bus_wdata[0] && !peer_irq_in) |=> !irq_out);
endmodule

// File: tb/shm_bell_bank_bench.sv
module shm_bell_bank_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_rev = 1'b0;
    logic        cfg_irq_en = 1'b0;
    logic [15:0] cfg_local_id = 16'h0;
    logic [7:0]  bus_addr = 8'h0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = 32'h0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic        peer_irq_in = 1'b0;
    logic        ring_req;
    logic [15:0] ring_peer;
    logic [15:0] ring_vector;
    logic        irq_out;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    shm_bell_bank u_shm_bell_bank (
        .clk(clk), .rst(rst), .cfg_rev(cfg_rev), .cfg_irq_en(cfg_irq_en),
        .cfg_local_id(cfg_local_id), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .peer_irq_in(peer_irq_in), .ring_req(ring_req), .ring_peer(ring_peer),
        .ring_vector(ring_vector), .irq_out(irq_out)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R1 irq_out", {31'b0, irq_out}, 32'h0);
        check("R1 ring_req", {31'b0, ring_req}, 32'h0);
        check("R1 rdata", bus_rdata, 32'h0);
        rd(8'h00, v); check("R1 mask", v, 32'h0);
        rd(8'h04, v); check("R1 status", v, 32'h0);
    endtask

    task automatic t_mask_status();
        logic [31:0] v;
        cfg_rev = 1'b1;
        wr(8'h00, 32'hA5C3_0F7E); rd(8'h00, v); check("R2 mask pattern", v, 32'hA5C3_0F7E);
        wr(8'h04, 32'h8000_0001); rd(8'h04, v); check("R2 status pattern", v, 32'h8000_0001);
        wr(8'h00, 32'hFFFF_FFFF); rd(8'h00, v); check("R2 mask ones", v, 32'hFFFF_FFFF);
        wr(8'h00, 32'h0); wr(8'h04, 32'h0);
        cfg_rev = 1'b0;
    endtask

    task automatic t_read_timing();
        logic [31:0] v;
        wr(8'h00, 32'h1234_5678);
        rd(8'h03, v); check("R3 low addr bits ignored", v, 32'h1234_5678);
        @(negedge clk); check("R3 zero after read", bus_rdata, 32'h0);
        wr(8'h00, 32'h0);
    endtask

    task automatic t_position();
        logic [31:0] v;
        cfg_local_id = 16'hBEEF;
        cfg_irq_en = 1'b0;
        rd(8'h08, v); check("R4 pos disabled", v, 32'h0);
        cfg_irq_en = 1'b1;
        rd(8'h08, v); check("R4 pos enabled", v, 32'h0000_BEEF);
        wr(8'h08, 32'h5555_5555);
        rd(8'h08, v); check("R4 pos write ignored", v, 32'h0000_BEEF);
        cfg_local_id = 16'hFFFF;
        rd(8'h08, v); check("R4 pos max id", v, 32'h0000_FFFF);
    endtask

    task automatic t_bell_on();
        cfg_irq_en = 1'b1;
        wr(8'h0C, 32'h0007_0003);
        check("R5 req pulse", {31'b0, ring_req}, 32'h1);
        check("R5 peer", {16'h0, ring_peer}, 32'h0007);
        check("R5 vector", {16'h0, ring_vector}, 32'h0003);
        @(negedge clk); check("R5 req one cycle", {31'b0, ring_req}, 32'h0);
        @(negedge clk);
        bus_addr = 8'h0C; bus_wdata = 32'hAAAA_0001; bus_wr = 1'b1;
        @(negedge clk);
        bus_wdata = 32'h5555_0002;
        check("R5 b2b first req", {31'b0, ring_req}, 32'h1);
        check("R5 b2b first data", {ring_peer, ring_vector}, 32'hAAAA_0001);
        @(negedge clk);
        bus_wr = 1'b0;
        check("R5 b2b second req", {31'b0, ring_req}, 32'h1);
        check("R5 b2b second data", {ring_peer, ring_vector}, 32'h5555_0002);
        @(negedge clk); check("R5 b2b end", {31'b0, ring_req}, 32'h0);
    endtask

    task automatic t_bell_off();
        cfg_irq_en = 1'b0;
        wr(8'h0C, 32'h0009_0009);
        check("R6 no req", {31'b0, ring_req}, 32'h0);
        @(negedge clk); check("R6 no req later", {31'b0, ring_req}, 32'h0);
        cfg_irq_en = 1'b1;
    endtask

    task automatic t_reserved();
        logic [31:0] v;
        wr(8'h00, 32'h0F0F_0F0E); wr(8'h04, 32'hF0F0_F0F0);
        rd(8'h0C, v); check("R7 bell reads zero", v, 32'h0);
        for (int a = 16; a < 256; a += 60) begin
            wr(8'(a), 32'hDEAD_BEEF);
            rd(8'(a), v); check("R7 reserved reads zero", v, 32'h0);
        end
        wr(8'hFC, 32'hFFFF_FFFF);
        rd(8'h00, v); check("R7 mask untouched", v, 32'h0F0F_0F0E);
        rd(8'h04, v); check("R7 status untouched", v, 32'hF0F0_F0F0);
        wr(8'h00, 32'h0); wr(8'h04, 32'h0);
    endtask

    task automatic pulse_peer();
        @(negedge clk); peer_irq_in = 1'b1;
        @(negedge clk); peer_irq_in = 1'b0;
    endtask

    task automatic t_peer();
        logic [31:0] v;
        cfg_rev = 1'b0; cfg_irq_en = 1'b1;
        pulse_peer(); rd(8'h04, v); check("R8 rev0 peer sets bit0", v, 32'h1);
        wr(8'h04, 32'h0);
        @(negedge clk);
        bus_addr = 8'h04; bus_wdata = 32'h0000_0100; bus_wr = 1'b1; peer_irq_in = 1'b1;
        @(negedge clk); bus_wr = 1'b0; peer_irq_in = 1'b0;
        rd(8'h04, v); check("R8 peer beats clear", v, 32'h0000_0101);
        wr(8'h04, 32'h0);
        cfg_rev = 1'b1;
        pulse_peer(); rd(8'h04, v); check("R8 rev1 ignored", v, 32'h0);
        cfg_rev = 1'b0; cfg_irq_en = 1'b0;
        pulse_peer(); rd(8'h04, v); check("R8 disabled ignored", v, 32'h0);
        cfg_irq_en = 1'b1;
    endtask

    task automatic t_irq();
        cfg_rev = 1'b0;
        wr(8'h00, 32'h1);
        check("R9 mask only", {31'b0, irq_out}, 32'h0);
        wr(8'h04, 32'h1);
        check("R9 mask and status", {31'b0, irq_out}, 32'h1);
        cfg_rev = 1'b1;
        @(negedge clk); check("R9 rev1 no irq", {31'b0, irq_out}, 32'h0);
        cfg_rev = 1'b0;
        @(negedge clk); check("R9 rev0 again", {31'b0, irq_out}, 32'h1);
        wr(8'h04, 32'h0);
        check("R10 clear drops irq", {31'b0, irq_out}, 32'h0);
        wr(8'h00, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_mask_status();
        t_read_timing();
        t_position();
        t_bell_on();
        t_bell_off();
        t_reserved();
        t_peer();
        t_irq();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #400000;
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule